// File: doc/BRIEF.md
# Serial Subcode Word Transmitter

This block turns a stream of 7-bit subcode symbols into a self-framed serial line. Every word goes out as a single high start bit followed by seven data bits, most significant first. The data bits in sending order are Q, R, S, T, U, V, W, and they map to `sym_data[6]` down to `sym_data[0]`. Between words the line rests low for an idle gap whose length is set by a configuration input. A word flagged as the first of a block is preceded by an extra long low pause. A receiver treats that pause as the block sync.

All line timing is counted in bit periods. A bit period is the interval between two pulses of the `bit_en` input, which the surrounding logic derives from the word clock. Half a word-clock period, about 11.3/n µs at disc speed n, is one bit period. Symbols arrive over a valid/ready handshake. One symbol can wait in a holding register while the gap runs, so back-to-back words keep exactly the programmed spacing. A position counter tracks where the most recently started word sits inside a 96-word block.

Top module: `subtx_top`

## Requirements
- R1: While `rst_n` is low, `ser_out` is 0, `sym_ready` is 1 and `blk_pos` is BLOCK_WORDS-1 (95).
- R2: `sym_ready` is high only when the transmitter is idle or in a gap and holds no pending symbol. A symbol is taken only on a cycle with `sym_valid` and `sym_ready` both high. `sym_ready` is low in the cycle after an acceptance, and `sym_valid` pulses while `sym_ready` is low cause no word.
- R3: A word is one high start bit followed by `sym_data[6]` (Q) down to `sym_data[0]` (W), one bit per bit period. `ser_out` changes only on clock edges at which `bit_en` is high.
- R4: Between two back-to-back words the line is low for exactly G bit periods. G is `cfg_gap` clamped to the range 1 to 8: a value of 0 gives 1, and values above 8 give 8.
- R5: A symbol accepted with `sym_block_start` high is preceded by SYNC_BITS (18) further low bit periods, added after the gap G.
- R6: With no symbol pending, the line stays low and `sym_ready` stays high.
- R7: When a word starts, `blk_pos` becomes 0 if the word was flagged as a block start. Otherwise it becomes the previous value plus one, wrapping from 95 to 0.
- R8: A symbol accepted while the transmitter is idle starts its first bit period, or its sync pause, at the first `bit_en` edge after the acceptance cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle pulse marking each bit-period boundary |
| cfg_gap | input | GAP_CFG_W (4) | Requested idle gap in bit periods, clamped to 1..8 |
| sym_valid | input | 1 | Symbol offered |
| sym_data | input | DATA_W (7) | Symbol; bit 6 is Q, bit 0 is W |
| sym_block_start | input | 1 | Symbol opens a new block and gets the sync pause |
| sym_ready | output | 1 | Transmitter can take a symbol this cycle |
| ser_out | output | 1 | Serial subcode line, low when idle |
| blk_pos | output | POS_W (7) | Index of the most recently started word within its block |

## Verification
The assertions assume that `bit_en` is a single-cycle pulse separated by at least one clock without it. They also assume that `sym_data` and `sym_block_start` are meaningful only on the accepting cycle. The bench drives `bit_en` once every fourth clock from a free-running divider. It raises `sym_valid` for exactly one cycle, and only after it has seen `sym_ready` high at a falling edge. Deliberate offers made while `sym_ready` is low exercise the ignore path without breaking these assumptions.

// File: rtl/subtx_pkg.sv
package subtx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SYNC = 2'd1,
        ST_SEND = 2'd2,
        ST_GAP  = 2'd3
    } subtx_st_e;

    // Limit a requested gap to the legal range 1..gmax.
    function automatic int gap_clamp(input int req, input int gmax);
        if (req < 1)
            return 1;
        else if (req > gmax)
            return gmax;
        else
            return req;
    endfunction

endpackage

// File: rtl/subtx_ser.sv
// Word shifter: holds start bit plus data, line is the MSB of the register.
module subtx_ser #(
    parameter int DATA_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv,
    input  logic [DATA_W-1:0] data,
    output logic              line,
    output logic              done
);
    localparam int WORD_BITS = DATA_W + 1;
    localparam int CNT_W     = $clog2(WORD_BITS);

    typedef struct packed {
        logic [WORD_BITS-1:0] sh;
        logic [CNT_W-1:0]     cnt;
    } ser_s;

    ser_s cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (load) begin
            nxt_d.sh  = {1'b1, data};
            nxt_d.cnt = CNT_W'(DATA_W);
        end else if (adv) begin
            nxt_d.sh = {cur_q.sh[WORD_BITS-2:0], 1'b0};
            if (cur_q.cnt != '0)
                nxt_d.cnt = cur_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_q <= '0;
        else
            cur_q <= nxt_d;
    end

    assign line = cur_q.sh[WORD_BITS-1];
    assign done = (cur_q.cnt == '0);

endmodule

// File: rtl/subtx_tmr.sv
// Shared down counter for the sync pause and the inter-word gap.
module subtx_tmr #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = val;
        else if (dec && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/subtx_pos.sv
// Word position inside a block.
module subtx_pos #(
    parameter int BLOCK_WORDS = 96,
    parameter int POS_W       = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             restart,
    output logic [POS_W-1:0] pos
);
    localparam logic [POS_W-1:0] LAST = POS_W'(BLOCK_WORDS - 1);

    logic [POS_W-1:0] pos_q, pos_d;

    always_comb begin
        pos_d = pos_q;
        if (start) begin
            if (restart || pos_q == LAST)
                pos_d = '0;
            else
                pos_d = pos_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            pos_q <= LAST;
        else
            pos_q <= pos_d;
    end

    assign pos = pos_q;

endmodule

// File: rtl/subtx_top.sv
module subtx_top
    import subtx_pkg::*;
#(
    parameter int DATA_W      = 7,
    parameter int SYNC_BITS   = 18,
    parameter int GAP_MAX     = 8,
    parameter int GAP_CFG_W   = 4,
    parameter int BLOCK_WORDS = 96,
    parameter int POS_W       = $clog2(BLOCK_WORDS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_en,
    input  logic [GAP_CFG_W-1:0] cfg_gap,
    input  logic                 sym_valid,
    input  logic [DATA_W-1:0]    sym_data,
    input  logic                 sym_block_start,
    output logic                 sym_ready,
    output logic                 ser_out,
    output logic [POS_W-1:0]     blk_pos
);
    localparam int TMR_MAX = (SYNC_BITS > GAP_MAX) ? SYNC_BITS : GAP_MAX;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam logic [TMR_W-1:0] SYNC_LOAD = TMR_W'(SYNC_BITS - 1);

    typedef struct packed {
        subtx_st_e         st;
        logic              pend;
        logic [DATA_W-1:0] hold;
        logic              flag;
    } top_s;

    top_s cur_q, nxt_d;

    logic             accept;
    logic             ser_load, ser_adv, ser_done, ser_line;
    logic             tmr_load, tmr_dec, tmr_zero;
    logic [TMR_W-1:0] tmr_val, gap_load;
    logic             pos_start;

    assign sym_ready = (cur_q.st == ST_IDLE || cur_q.st == ST_GAP) && !cur_q.pend;
    assign accept    = sym_valid && sym_ready;
    assign gap_load  = TMR_W'(gap_clamp(int'(cfg_gap), GAP_MAX) - 1);
    assign tmr_dec   = bit_en && (cur_q.st == ST_SYNC || cur_q.st == ST_GAP);

    always_comb begin
        nxt_d     = cur_q;
        ser_load  = 1'b0;
        ser_adv   = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        pos_start = 1'b0;

        if (accept) begin
            nxt_d.pend = 1'b1;
            nxt_d.hold = sym_data;
            nxt_d.flag = sym_block_start;
        end

        case (cur_q.st)
            ST_IDLE: begin
                if (bit_en && cur_q.pend) begin
                    pos_start  = 1'b1;
                    nxt_d.pend = 1'b0;
                    if (cur_q.flag) begin
                        nxt_d.st = ST_SYNC;
                        tmr_load = 1'b1;
                        tmr_val  = SYNC_LOAD;
                    end else begin
                        nxt_d.st = ST_SEND;
                        ser_load = 1'b1;
                    end
                end
            end
            ST_SYNC: begin
                if (bit_en && tmr_zero) begin
                    nxt_d.st = ST_SEND;
                    ser_load = 1'b1;
                end
            end
            ST_SEND: begin
                if (bit_en) begin
                    ser_adv = 1'b1;
                    if (ser_done) begin
                        nxt_d.st = ST_GAP;
                        tmr_load = 1'b1;
                        tmr_val  = gap_load;
                    end
                end
            end
            ST_GAP: begin
                if (bit_en && tmr_zero) begin
                    if (cur_q.pend) begin
                        pos_start  = 1'b1;
                        nxt_d.pend = 1'b0;
                        if (cur_q.flag) begin
                            nxt_d.st = ST_SYNC;
                            tmr_load = 1'b1;
                            tmr_val  = SYNC_LOAD;
                        end else begin
                            nxt_d.st = ST_SEND;
                            ser_load = 1'b1;
                        end
                    end else begin
                        nxt_d.st = ST_IDLE;
                    end
                end
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.st   <= ST_IDLE;
            cur_q.pend <= 1'b0;
            cur_q.hold <= '0;
            cur_q.flag <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    subtx_ser #(
        .DATA_W(DATA_W)
    ) u_ser (
        .clk  (clk),
        .rst_n(rst_n),
        .load (ser_load),
        .adv  (ser_adv),
        .data (cur_q.hold),
        .line (ser_line),
        .done (ser_done)
    );

    subtx_tmr #(
        .W(TMR_W)
    ) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .load (tmr_load),
        .val  (tmr_val),
        .dec  (tmr_dec),
        .zero (tmr_zero)
    );

    subtx_pos #(
        .BLOCK_WORDS(BLOCK_WORDS),
        .POS_W      (POS_W)
    ) u_pos (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (pos_start),
        .restart(cur_q.flag),
        .pos    (blk_pos)
    );

    assign ser_out = ser_line;

endmodule

// File: rtl/subtx_chk.sv
module subtx_chk #(
    parameter int DATA_W      = 7,
    parameter int BLOCK_WORDS = 96,
    parameter int POS_W       = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_en,
    input logic             sym_valid,
    input logic             sym_ready,
    input logic             ser_out,
    input logic [POS_W-1:0] blk_pos
);
    localparam int WORD_BITS = DATA_W + 1;
    localparam int RUN_W     = $clog2(WORD_BITS + 2);

    // Bit-period edges seen while the line was high, reset by any low cycle.
    logic [RUN_W-1:0] hi_run;

    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_run <= '0;
        else if (!ser_out)
            hi_run <= '0;
        else if (bit_en && hi_run != '1)
            hi_run <= hi_run + 1'b1;
    end

    AST_LINE_ON_BIT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(ser_out));                                   // R3
    AST_HIGH_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(hi_run) <= WORD_BITS);                                      // R3
    AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && sym_ready) |=> !sym_ready);                        // R2
    AST_READY_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        sym_ready |-> !ser_out);                                         // R6
    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(blk_pos) < BLOCK_WORDS);                                    // R7

endmodule

bind subtx_top subtx_chk #(
    .DATA_W     (DATA_W),
    .BLOCK_WORDS(BLOCK_WORDS),
    .POS_W      (POS_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .sym_valid(sym_valid),
    .sym_ready(sym_ready),
    .ser_out  (ser_out),
    .blk_pos  (blk_pos)
);

// File: tb/subtx_top_bench.sv
`timescale 1ns/1ps
module subtx_top_bench;
    localparam int DATA_W  = 7;
    localparam int SYNC    = 18;
    localparam int BW      = 96;
    localparam int CAP_MAX = 4096;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bit_en;
    logic [3:0] cfg_gap;
    logic       sym_valid;
    logic [6:0] sym_data;
    logic       sym_block_start;
    logic       sym_ready;
    logic       ser_out;
    logic [6:0] blk_pos;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_pos = BW - 1;
    logic cap [0:CAP_MAX-1];
    int cap_n = 0;
    logic en_seen = 1'b0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    subtx_top u_subtx_top (
        .clk            (clk),
        .rst_n          (rst_n),
        .bit_en         (bit_en),
        .cfg_gap        (cfg_gap),
        .sym_valid      (sym_valid),
        .sym_data       (sym_data),
        .sym_block_start(sym_block_start),
        .sym_ready      (sym_ready),
        .ser_out        (ser_out),
        .blk_pos        (blk_pos)
    );

    // bit_en: one cycle in four
    initial begin
        int div = 0;
        bit_en = 1'b0;
        forever begin
            @(negedge clk);
            div = (div + 1) % 4;
            bit_en = (div == 0);
        end
    end

    // record the line once per bit period, just after each bit edge
    initial begin
        forever begin
            @(posedge clk);
            en_seen = bit_en;
            @(negedge clk);
            if (en_seen && cap_n < CAP_MAX) begin
                cap[cap_n] = ser_out;
                cap_n++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_per(input int n);
        repeat (n * 4) @(negedge clk);
    endtask

    task automatic send(input logic [6:0] d, input logic flag);
        @(negedge clk);
        while (!sym_ready) @(negedge clk);
        sym_valid = 1'b1;
        sym_data = d;
        sym_block_start = flag;
        @(negedge clk);
        sym_valid = 1'b0;
        exp_pos = flag ? 0 : (exp_pos + 1) % BW;
    endtask

    function automatic int find_one(input int from);
        for (int k = from; k < cap_n; k++)
            if (cap[k] === 1'b1) return k;
        return -1;
    endfunction

    function automatic int get8(input int i);
        int v = 0;
        for (int k = 0; k < 8; k++)
            v = (v << 1) | ((i + k < cap_n && cap[i + k] === 1'b1) ? 1 : 0);
        return v;
    endfunction

    function automatic int ones_in(input int lo, input int hi);
        int c = 0;
        for (int k = lo; k < hi; k++)
            if (k < cap_n && cap[k] !== 1'b0) c++;
        return c;
    endfunction

    task automatic t_reset();
        chk(ser_out == 1'b0, "R1 line low in reset", int'(ser_out), 0);
        chk(sym_ready == 1'b1, "R1 ready in reset", int'(sym_ready), 1);
        chk(int'(blk_pos) == BW - 1, "R1 position in reset", int'(blk_pos), BW - 1);
    endtask

    task automatic t_idle();
        cap_n = 0;
        wait_per(30);
        chk(ones_in(0, cap_n) == 0, "R6 idle line high periods", ones_in(0, cap_n), 0);
        chk(sym_ready == 1'b1, "R6 ready while idle", int'(sym_ready), 1);
    endtask

    task automatic t_single();
        int i;
        cfg_gap = 4'd3;
        cap_n = 0;
        send(7'b1011001, 1'b0);
        chk(sym_ready == 1'b0, "R2 ready low after accept", int'(sym_ready), 0);
        sym_valid = 1'b1;
        sym_data = 7'h7F;
        sym_block_start = 1'b0;
        repeat (2) @(negedge clk);
        sym_valid = 1'b0;
        wait_per(30);
        i = find_one(0);
        chk(i >= 1 && i <= 2, "R8 start period after idle accept", i, 1);
        chk(get8(i) == 8'b11011001, "R3 word bits", get8(i), 8'b11011001);
        chk(ones_in(0, cap_n) == 5, "R2 offer while not ready ignored", ones_in(0, cap_n), 5);
        chk(int'(blk_pos) == exp_pos, "R7 first word position", int'(blk_pos), exp_pos);
    endtask

    task automatic t_b2b(input logic [3:0] gcfg, input int geff,
                         input logic [6:0] a, input logic [6:0] b);
        int i, j;
        cfg_gap = gcfg;
        cap_n = 0;
        send(a, 1'b0);
        send(b, 1'b0);
        wait_per(40);
        i = find_one(0);
        j = i + 8 + geff;
        chk(get8(i) == int'({1'b1, a}), "R3 first word bits", get8(i), int'({1'b1, a}));
        chk(ones_in(i + 8, j) == 0, "R4 gap low", ones_in(i + 8, j), 0);
        chk(find_one(i + 8) == j, "R4 gap length", find_one(i + 8) - i - 8, geff);
        chk(get8(j) == int'({1'b1, b}), "R3 second word bits", get8(j), int'({1'b1, b}));
        chk(int'(blk_pos) == exp_pos, "R7 position after pair", int'(blk_pos), exp_pos);
    endtask

    task automatic t_sync();
        int i, j;
        cfg_gap = 4'd2;
        cap_n = 0;
        send(7'b0101010, 1'b0);
        send(7'b1110001, 1'b1);
        wait_per(60);
        i = find_one(0);
        j = i + 8 + 2 + SYNC;
        chk(ones_in(i + 8, j) == 0, "R5 sync pause low", ones_in(i + 8, j), 0);
        chk(find_one(i + 8) == j, "R5 sync pause length", find_one(i + 8) - i - 8, 2 + SYNC);
        chk(get8(j) == 8'b11110001, "R5 word after sync", get8(j), 8'b11110001);
        chk(int'(blk_pos) == 0, "R7 block start resets position", int'(blk_pos), 0);
    endtask

    task automatic t_wrap();
        cfg_gap = 4'd1;
        send(7'h11, 1'b1);
        for (int k = 1; k < BW; k++) send(7'(k), 1'b0);
        wait_per(20);
        chk(int'(blk_pos) == BW - 1, "R7 last word of block", int'(blk_pos), BW - 1);
        send(7'h22, 1'b0);
        wait_per(20);
        chk(int'(blk_pos) == 0, "R7 position wraps", int'(blk_pos), 0);
    endtask

    initial begin
        rst_n = 1'b0;
        cfg_gap = 4'd1;
        sym_valid = 1'b0;
        sym_data = '0;
        sym_block_start = 1'b0;
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_idle();
        t_single();
        t_b2b(4'd0, 1, 7'b1100101, 7'b0110011);
        t_b2b(4'd3, 3, 7'b0000001, 7'b1000000);
        t_b2b(4'd8, 8, 7'b1111111, 7'b0000000);
        t_b2b(4'd13, 8, 7'b0101101, 7'b1010010);
        t_sync();
        t_wrap();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule